// File: doc/BRIEF.md
# Multicycle Load/Store Processor Controller

This block sequences a small 32-bit load/store processor core that uses one shared memory for both instruction fetch and data access. A single enumerated state machine carries each instruction through a few shared steps: fetch, decode, then the steps that belong to that instruction class. It then returns to fetch. In every state it drives the datapath selects and write enables. These cover the memory address source, the memory read and write strobes, the instruction register load, the register write-back source and destination, the two ALU operand selects, the ALU operation class, the PC source, and the unconditional and conditional PC write enables.

The datapath registers sit inside the block so that the controller can be exercised end to end against an external memory. These are the PC, the instruction register, the memory data register, the two operand registers, the ALU result register and a 32-entry register file. Memory is word addressed through byte addresses. Reads are combinational and writes take effect at the clock edge in which the write strobe is high. The current state and the PC are brought out so that instruction timing can be observed.

States and transitions:
- `ST_FETCH` goes to `ST_DECODE`.
- `ST_DECODE` goes to one of five places, depending on the opcode:
  - `ST_ADDR` for a load or a store
  - `ST_REXE` for register-register operations
  - `ST_BEQ` for branch-if-equal
  - `ST_JMP` for a jump
  - `ST_FETCH` for any other opcode
- `ST_ADDR` goes to `ST_LDRD` for a load or to `ST_STWR` for a store.
- `ST_LDRD` goes to `ST_LDWB`.
- `ST_REXE` goes to `ST_RWB`.
- `ST_LDWB`, `ST_STWR`, `ST_RWB`, `ST_BEQ` and `ST_JMP` all return to `ST_FETCH`.

Top module: `mcc_top`

## Requirements
- R1: While reset is low, `fsm_state` is 0 (fetch) and `pc_q` is 0, `mem_rd` is 1, `mem_wr` is 0 and `mem_addr` is 0.
- R2: In the fetch state (code 0) the block reads memory at the PC and loads the instruction register. One cycle later the PC has grown by 4 and the state is decode (code 1).
- R3: Decode dispatches on instruction bits [31:26]. The codes are 0x00 for register-register, 0x23 for load, 0x2B for store, 0x04 for branch-if-equal and 0x02 for jump. Any other opcode returns to fetch, so such an instruction takes 2 cycles and changes no register or memory.
- R4: A load takes 5 cycles. It writes the memory word at rs + sign-extended imm[15:0] into register rt. Here rs is bits [25:21] and rt is bits [20:16].
- R5: A store takes 4 cycles. It writes register rt to the memory address rs + sign-extended imm. The memory write strobe is high only in the store state (code 5).
- R6: A register-register instruction takes 4 cycles and writes register rd (bits [15:11]). The operation is chosen by bits [5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x27 nor, 0x2A signed set-less-than.
- R7: Branch-if-equal takes 3 cycles. When rs equals rt, the PC becomes PC+4 + (sign-extended imm << 2). Otherwise it stays at PC+4.
- R8: A jump takes 3 cycles and sets the PC to {PC+4[31:28], bits[25:0], 2'b00}.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: The memory read and write strobes are never high in the same cycle. Outside fetch, branch and jump states, the PC does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 32 | Byte address to the shared memory (PC or ALU result register) |
| mem_wdata | output | 32 | Store data (operand register B) |
| mem_rdata | input | 32 | Combinational read data from memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe, applied at the next rising edge |
| pc_q | output | 32 | Current program counter |
| fsm_state | output | 4 | Current controller state code |

## Verification
The PC advances one edge after the fetch cycle begins. A load's register write lands at the edge that ends its fifth cycle, a store's memory write at the edge that ends its fourth, and a taken branch or jump updates the PC at the edge that ends its third. The bench samples on falling edges. It measures each instruction from the falling edge at which fetch is first seen to the next falling edge at which fetch is seen again. That count is compared against the required cycle count, and the PC latched in the fetch cycle is compared against the expected instruction address. Register results are brought out through store instructions and read from the memory model only after the program has reached its final self-loop.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREG   = 1 << REG_AW;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_REXE   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BEQ    = 4'd8,
        ST_JMP    = 4'd9
    } state_t;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_JMP  = 6'h02;

    typedef enum logic [1:0] {
        OPB_REG   = 2'd0,
        OPB_FOUR  = 2'd1,
        OPB_IMM   = 2'd2,
        OPB_IMMSH = 2'd3
    } opb_sel_t;

    typedef enum logic [1:0] {
        NPC_ALU  = 2'd0,
        NPC_HELD = 2'd1,
        NPC_JUMP = 2'd2
    } npc_sel_t;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_FUNCT = 2'd2
    } alu_cls_t;

    typedef struct packed {
        logic     addr_from_res;
        logic     mem_rd;
        logic     mem_wr;
        logic     ir_load;
        logic     wb_from_mem;
        logic     dst_is_rd;
        logic     reg_we;
        logic     opa_is_reg;
        opb_sel_t opb_sel;
        alu_cls_t alu_cls;
        npc_sel_t npc_sel;
        logic     pc_we;
        logic     pc_we_if_eq;
    } ctrl_t;

endpackage

// File: rtl/mcc_fsm.sv
module mcc_fsm
    import mcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    output state_t     state,
    output ctrl_t      ctrl
);

    state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode)
                    OPC_REG:  state_d = ST_REXE;
                    OPC_LOAD,
                    OPC_STOR: state_d = ST_ADDR;
                    OPC_BEQ:  state_d = ST_BEQ;
                    OPC_JMP:  state_d = ST_JMP;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_ADDR:   state_d = (opcode == OPC_LOAD) ? ST_LDRD : ST_STWR;
            ST_LDRD:   state_d = ST_LDWB;
            ST_REXE:   state_d = ST_RWB;
            ST_LDWB,
            ST_STWR,
            ST_RWB,
            ST_BEQ,
            ST_JMP:    state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // per-state control outputs
    always_comb begin
        ctrl = '0;
        ctrl.opb_sel = OPB_REG;
        ctrl.alu_cls = ALU_ADD;
        ctrl.npc_sel = NPC_ALU;
        unique case (state_q)
            ST_FETCH: begin
                ctrl.mem_rd  = 1'b1;
                ctrl.ir_load = 1'b1;
                ctrl.opb_sel = OPB_FOUR;
                ctrl.pc_we   = 1'b1;
            end
            ST_DECODE: begin
                ctrl.opb_sel = OPB_IMMSH;
            end
            ST_ADDR: begin
                ctrl.opa_is_reg = 1'b1;
                ctrl.opb_sel    = OPB_IMM;
            end
            ST_LDRD: begin
                ctrl.mem_rd        = 1'b1;
                ctrl.addr_from_res = 1'b1;
            end
            ST_LDWB: begin
                ctrl.reg_we      = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            ST_STWR: begin
                ctrl.mem_wr        = 1'b1;
                ctrl.addr_from_res = 1'b1;
            end
            ST_REXE: begin
                ctrl.opa_is_reg = 1'b1;
                ctrl.alu_cls    = ALU_FUNCT;
            end
            ST_RWB: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
            end
            ST_BEQ: begin
                ctrl.opa_is_reg  = 1'b1;
                ctrl.alu_cls     = ALU_SUB;
                ctrl.npc_sel     = NPC_HELD;
                ctrl.pc_we_if_eq = 1'b1;
            end
            ST_JMP: begin
                ctrl.npc_sel = NPC_JUMP;
                ctrl.pc_we   = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
    import mcc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_cls_t     cls,
    input  logic [5:0]   funct,
    output logic [W-1:0] res,
    output logic         is_zero
);

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    always_comb begin
        res = opa + opb;
        unique case (cls)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_FUNCT: begin
                unique case (funct)
                    FN_ADD:  res = opa + opb;
                    FN_SUB:  res = opa - opb;
                    FN_AND:  res = opa & opb;
                    FN_OR:   res = opa | opb;
                    FN_NOR:  res = ~(opa | opb);
                    FN_SLT:  res = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
                    default: res = opa + opb;
                endcase
            end
            default: res = opa + opb;
        endcase
    end

    assign is_zero = (res == '0);

endmodule

// File: rtl/mcc_dp.sv
module mcc_dp
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [5:0]      opcode,
    output logic [XLEN-1:0] pc_q
);

    logic [XLEN-1:0] pc, ir, mdr, reg_a, reg_b, res_q;
    logic [XLEN-1:0] rf [NREG];
    logic [XLEN-1:0] opa, opb, alu_y, imm_sx, pc_next, wb_data, rd_a, rd_b;
    logic [REG_AW-1:0] rs_f, rt_f, rd_f, wb_idx;
    logic            alu_zero, pc_en;

    assign rs_f   = ir[25:21];
    assign rt_f   = ir[20:16];
    assign rd_f   = ir[15:11];
    assign imm_sx = {{(XLEN-16){ir[15]}}, ir[15:0]};

    // register file; index 0 stays zero
    assign rd_a = (rs_f == '0) ? '0 : rf[rs_f];
    assign rd_b = (rt_f == '0) ? '0 : rf[rt_f];
    assign wb_idx  = ctrl.dst_is_rd   ? rd_f : rt_f;
    assign wb_data = ctrl.wb_from_mem ? mdr  : res_q;

    always_ff @(posedge clk) begin
        if (ctrl.reg_we && wb_idx != '0) rf[wb_idx] <= wb_data;
    end

    // operand selects
    assign opa = ctrl.opa_is_reg ? reg_a : pc;
    always_comb begin
        unique case (ctrl.opb_sel)
            OPB_REG:   opb = reg_b;
            OPB_FOUR:  opb = XLEN'(4);
            OPB_IMM:   opb = imm_sx;
            OPB_IMMSH: opb = {imm_sx[XLEN-3:0], 2'b00};
            default:   opb = reg_b;
        endcase
    end

    mcc_alu #(.W(XLEN)) u_alu (
        .opa     (opa),
        .opb     (opb),
        .cls     (ctrl.alu_cls),
        .funct   (ir[5:0]),
        .res     (alu_y),
        .is_zero (alu_zero)
    );

    // next PC
    always_comb begin
        unique case (ctrl.npc_sel)
            NPC_ALU:  pc_next = alu_y;
            NPC_HELD: pc_next = res_q;
            NPC_JUMP: pc_next = {pc[XLEN-1:XLEN-4], ir[25:0], 2'b00};
            default:  pc_next = alu_y;
        endcase
    end
    assign pc_en = ctrl.pc_we | (ctrl.pc_we_if_eq & alu_zero);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            mdr   <= '0;
            reg_a <= '0;
            reg_b <= '0;
            res_q <= '0;
        end else begin
            if (pc_en)        pc <= pc_next;
            if (ctrl.ir_load) ir <= mem_rdata;
            mdr   <= mem_rdata;
            reg_a <= rd_a;
            reg_b <= rd_b;
            res_q <= alu_y;
        end
    end

    assign mem_addr  = ctrl.addr_from_res ? res_q : pc;
    assign mem_wdata = reg_b;
    assign mem_rd    = ctrl.mem_rd;
    assign mem_wr    = ctrl.mem_wr;
    assign opcode    = ir[31:26];
    assign pc_q      = pc;

endmodule

// File: rtl/mcc_top.sv
module mcc_top
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] pc_q,
    output logic [3:0]      fsm_state
);

    state_t     st;
    ctrl_t      ctrl;
    logic [5:0] opcode;

    mcc_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .state  (st),
        .ctrl   (ctrl)
    );

    mcc_dp u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .opcode    (opcode),
        .pc_q      (pc_q)
    );

    assign fsm_state = st;

endmodule

// File: rtl/mcc_top_chk.sv
module mcc_top_chk
    import mcc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      fsm_state,
    input logic [XLEN-1:0] pc_q,
    input logic            mem_rd,
    input logic            mem_wr
);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_decode_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FETCH) |=> (fsm_state == ST_DECODE));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_FETCH) |=> (pc_q == $past(pc_q) + 32'd4));

    p_load_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_LDRD) |=> (fsm_state == ST_LDWB));

    p_write_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (fsm_state == ST_STWR));

    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_FETCH && fsm_state != ST_BEQ && fsm_state != ST_JMP)
        |=> $stable(pc_q));

    p_short_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_BEQ || fsm_state == ST_JMP) |=> (fsm_state == ST_FETCH));

endmodule

bind mcc_top mcc_top_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsm_state (fsm_state),
    .pc_q      (pc_q),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/mcc_top_test.sv
`timescale 1ns/1ps
module mcc_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_q;
    logic        mem_rd, mem_wr;
    logic [3:0]  fsm_state;
    logic [31:0] mem [64];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mcc_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .pc_q      (pc_q),
        .fsm_state (fsm_state)
    );

    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;

    localparam int NPROG = 25;
    localparam logic [31:0] PROG [NPROG] = '{
        32'h8C0100A0, 32'h8C0200A4,                          // load r1, r2
        32'h00221820, 32'h00222022, 32'h00222824,            // add sub and
        32'h00223025, 32'h00223827, 32'h0041402A,            // or nor slt
        32'hAC0300A8, 32'hAC0400AC, 32'hAC0500B0,            // stores
        32'hAC0600B4, 32'hAC0700B8, 32'hAC0800BC,
        32'h10220005, 32'h10210002,                          // beq not taken, taken
        32'hAC0100C0, 32'hAC0100C0,                          // skipped
        32'h08000015,                                        // jump to word 21
        32'hAC0100C4, 32'hAC0100C4,                          // skipped
        32'h00210020, 32'hAC0000C8,                          // write r0, store r0
        32'hFC000000,                                        // unknown opcode
        32'h08000018                                         // self loop
    };

    // {expected fetch PC, expected cycles}
    localparam int NVEC = 21;
    localparam logic [39:0] VEC [NVEC] = '{
        {32'd0,  8'd5}, {32'd4,  8'd5},
        {32'd8,  8'd4}, {32'd12, 8'd4}, {32'd16, 8'd4},
        {32'd20, 8'd4}, {32'd24, 8'd4}, {32'd28, 8'd4},
        {32'd32, 8'd4}, {32'd36, 8'd4}, {32'd40, 8'd4},
        {32'd44, 8'd4}, {32'd48, 8'd4}, {32'd52, 8'd4},
        {32'd56, 8'd3}, {32'd60, 8'd3},
        {32'd72, 8'd3},
        {32'd84, 8'd4}, {32'd88, 8'd4},
        {32'd92, 8'd2},
        {32'd96, 8'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [31:0] instr);
        case (instr[31:26])
            6'h23:   return "R4 load";
            6'h2B:   return "R5 store";
            6'h00:   return "R6 reg-reg";
            6'h04:   return "R7 branch";
            6'h02:   return "R8 jump";
            default: return "R3 unknown opcode";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < NPROG; i++) mem[i] = PROG[i];
        mem[40] = 32'd5;
        mem[41] = 32'd3;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 state", {28'd0, fsm_state}, 32'd0);
        check("R1 pc", pc_q, 32'd0);
        check("R1 addr", mem_addr, 32'd0);
        check("R1 strobes", {30'd0, mem_rd, mem_wr}, 32'd2);
        rst_n = 1'b1;

        // R2 fetch: one edge later PC+4 and decode
        @(negedge clk);
        check("R2 pc step", pc_q, 32'd4);
        check("R2 decode", {28'd0, fsm_state}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            int    n;
            string rq;
            rq = req_of(mem[pc_q[7:2]]);
            check({rq, " pc"}, pc_q, VEC[v][39:8]);
            n = 1;
            @(negedge clk);
            while (fsm_state != 4'd0) begin
                n++;
                @(negedge clk);
            end
            check({rq, " cycles"}, n, {24'd0, VEC[v][7:0]});
        end

        check("R4/R6 add via store", mem[42], 32'd8);
        check("R6 sub", mem[43], 32'd2);
        check("R6 and", mem[44], 32'd1);
        check("R6 or", mem[45], 32'd7);
        check("R6 nor", mem[46], 32'hFFFFFFF8);
        check("R6 slt", mem[47], 32'd1);
        check("R7 skipped by branch", mem[48], 32'd0);
        check("R8 skipped by jump", mem[49], 32'd0);
        check("R9 r0 stays zero", mem[50], 32'd0);
        check("R3 loaded data intact", mem[40], 32'd5);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule